// File: doc/BRIEF.md
# Interrupt Status Mask Coalescer

This block keeps a status register of pending event bits and a mask register that selects which of them may reach the processor. It drives one interrupt line. Event sources set status bits through a post strobe and software removes them through a clear strobe. When a post leaves unmasked status active, delivery is scheduled after a programmable number of cycles, so that several events can share one interrupt. Bits in a small urgent set skip that wait.

An interrupt that is already scheduled is never moved to a later time. A newer request with a shorter wait pulls it in. A pending flag, which is the interrupt line itself, stops a second firing from raising the line again. A global enable gates all scheduling. The processor acknowledge input drops the line and discards any outstanding schedule.

Default encoding: 8 status bits. Bit 0 is transmit-FIFO, bit 1 is receive-FIFO, bit 2 is receive-data, bits 3 and 4 are urgent, bits 5 and 6 are ordinary, and bit 7 is reserved.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, status_o is 0x00, mask_o is 0x07 (bits 0, 1 and 2) and irq_o is low.
- R2: A post ORs post_bits into status. A post or clear whose vector has reserved bit 7 set changes nothing, and err_o is high for the cycle after the strobe.
- R3: A post sampled at clock edge k that leaves (status & mask) nonzero, with neither bit 3 nor bit 4 active in it, raises irq_o at edge k+delay_cyc. The delay sampled at edge k applies, and a delay of 0 raises irq_o at edge k itself.
- R4: If bit 3 or bit 4 is set in (status & mask) after a post at edge k, irq_o rises at edge k whatever the delay.
- R5: A new request never postpones a scheduled interrupt. If the new request would fire earlier, the schedule moves to the earlier edge.
- R6: A clear ANDs status with the complement of clr_bits. A post and a clear in the same cycle apply the post first. If (status & mask) becomes zero, irq_o drops at that edge and any schedule is discarded.
- R7: A mask write equal to the current mask has no effect. A mask write that differs from the current mask and leaves (status & new mask) nonzero raises irq_o at that edge.
- R8: While glb_en is low, nothing is scheduled and an outstanding schedule is discarded. A rising glb_en with (status & mask) nonzero raises irq_o at that edge.
- R9: A firing while irq_o is already high keeps irq_o high and produces no second assertion.
- R10: cpu_ack drops irq_o at the next edge and discards any outstanding schedule. It takes priority over a firing in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Post strobe |
| post_bits | input | 8 | Bits to set in status |
| clr_vld | input | 1 | Clear strobe |
| clr_bits | input | 8 | Bits to remove from status |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask value |
| glb_en | input | 1 | Global interrupt enable |
| delay_cyc | input | 8 | Coalescing delay in cycles |
| cpu_ack | input | 1 | Processor acknowledge and clear |
| irq_o | output | 1 | Interrupt line (pending flag) |
| status_o | output | 8 | Current status register |
| mask_o | output | 8 | Current mask register |
| err_o | output | 1 | Reserved-bit access seen in previous cycle |

## Verification
A wrong schedule counter shows up as irq_o rising on the wrong edge. For that reason every firing case is measured as an exact latency in cycles from the strobe, and not only as eventual assertion. A schedule that is not discarded on clear, acknowledge or disable shows up as a spurious rise up to delay_cyc cycles later, so the bench watches the line for longer than the delay after each of those events. A stuck pending flag shows up at once as irq_o failing to drop one edge after an acknowledge.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int              W        = 8,
  parameter int              DW       = 8,
  parameter logic [W-1:0]    RSVD     = 8'h80,
  parameter logic [W-1:0]    URGENT   = 8'h18,
  parameter logic [W-1:0]    MASK_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_vld,
  input  logic [W-1:0]  post_bits,
  input  logic          clr_vld,
  input  logic [W-1:0]  clr_bits,
  input  logic          mask_wr,
  input  logic [W-1:0]  mask_data,
  input  logic          glb_en,
  input  logic [DW-1:0] delay_cyc,
  input  logic          cpu_ack,
  output logic          irq_o,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  mask_o,
  output logic          err_o
);

  logic [W-1:0]  status_q, mask_q;
  logic [DW-1:0] cnt_q;
  logic          sched_q, pend_q, en_q, err_q;

  wire post_bad = post_vld && |(post_bits & RSVD);
  wire clr_bad  = clr_vld  && |(clr_bits  & RSVD);
  wire post_ok  = post_vld && !post_bad;
  wire clr_ok   = clr_vld  && !clr_bad;

  wire [W-1:0] st_nx    = (status_q | (post_ok ? post_bits : '0)) & ~(clr_ok ? clr_bits : '0);
  wire         mask_chg = mask_wr && (mask_data != mask_q);
  wire [W-1:0] mk_nx    = mask_chg ? mask_data : mask_q;
  wire [W-1:0] act_nx   = st_nx & mk_nx;

  wire en_rise  = glb_en && !en_q;
  wire req_post = post_ok && |act_nx;
  wire req_now  = (req_post && |(act_nx & URGENT)) || (mask_chg && |act_nx) || (en_rise && |act_nx);
  wire req_any  = req_post || req_now;
  wire [DW-1:0] req_d = req_now ? '0 : delay_cyc;

  wire          keep_old = sched_q && (!req_any || cnt_q <= req_d);
  wire [DW-1:0] m_cnt    = keep_old ? cnt_q : req_d;
  wire          m_act    = sched_q || req_any;

  wire withdraw = clr_ok && (act_nx == '0);
  wire drop     = cpu_ack || withdraw;
  wire kill     = drop || !glb_en;
  wire fire     = m_act && (m_cnt == '0) && !kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
      cnt_q    <= '0;
      sched_q  <= 1'b0;
      pend_q   <= 1'b0;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      status_q <= st_nx;
      mask_q   <= mk_nx;
      en_q     <= glb_en;
      err_q    <= post_bad || clr_bad;
      if (kill) begin
        sched_q <= 1'b0;
        if (drop) pend_q <= 1'b0;
      end else if (fire) begin
        sched_q <= 1'b0;
        pend_q  <= 1'b1;
      end else begin
        sched_q <= m_act;
        if (m_act) cnt_q <= m_cnt - 1'b1;
      end
    end
  end

  assign irq_o    = pend_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign err_o    = err_q;

  AST_RSVD_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RSVD) == '0); // R2
  AST_RSVD_POST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (post_bad && !clr_vld) |=> (status_q == $past(status_q))); // R2
  AST_NO_SCHED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !sched_q); // R8
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(glb_en)); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !irq_o); // R10

endmodule

// File: tb/irq_coalescer_tb.sv
module irq_coalescer_tb_top;
  logic clk = 0, rst_n = 0;
  logic post_vld = 0, clr_vld = 0, mask_wr = 0, glb_en = 1, cpu_ack = 0;
  logic [7:0] post_bits = 0, clr_bits = 0, mask_data = 0, delay_cyc = 0;
  logic irq_o, err_o;
  logic [7:0] status_o, mask_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_coalescer dut_i (.clk, .rst_n, .post_vld, .post_bits, .clr_vld, .clr_bits,
    .mask_wr, .mask_data, .glb_en, .delay_cyc, .cpu_ack, .irq_o, .status_o, .mask_o, .err_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; post_vld = 0; clr_vld = 0; mask_wr = 0; cpu_ack = 0; glb_en = 1; delay_cyc = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic post(input logic [7:0] b);
    post_vld = 1; post_bits = b; step(1); post_vld = 0;
  endtask

  task automatic clr(input logic [7:0] b);
    clr_vld = 1; clr_bits = b; step(1); clr_vld = 0;
  endtask

  task automatic wmask(input logic [7:0] m);
    mask_wr = 1; mask_data = m; step(1); mask_wr = 0;
  endtask

  task automatic ack();
    cpu_ack = 1; step(1); cpu_ack = 0;
  endtask

  task automatic wait_irq(input int maxc, output int lat);
    lat = 0;
    while (!irq_o && lat < maxc) begin step(1); lat++; end
    if (!irq_o) lat = -1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] masks [5] = '{8'h07, 8'h18, 8'h7F, 8'h20, 8'h00};
    do_reset();
    chk(status_o == 0, "R1 status", status_o, 0);
    chk(mask_o == 8'h07, "R1 mask", mask_o, 7);
    chk(!irq_o, "R1 irq", irq_o, 0);

    // R3 delay sweep
    for (int d = 0; d < 8; d++) begin
      do_reset(); delay_cyc = 8'(d); post(8'h01); wait_irq(20, lat);
      chk(lat == d, "R3 delay latency", lat, d);
    end

    // R3/R4 mask x bit sweep
    foreach (masks[m]) begin
      for (int b = 0; b < 7; b++) begin
        int exp;
        do_reset();
        if (masks[m] != 8'h07) wmask(masks[m]);
        delay_cyc = 3;
        post(8'(1 << b));
        wait_irq(10, lat);
        exp = !masks[m][b] ? -1 : ((b == 3 || b == 4) ? 0 : 3);
        chk(lat == exp, (b == 3 || b == 4) ? "R4 urgent sweep" : "R3 mask sweep", lat, exp);
      end
    end

    // R2 reserved
    do_reset(); post(8'h81);
    chk(status_o == 0, "R2 reserved post ignored", status_o, 0);
    chk(err_o == 1, "R2 err pulse", err_o, 1);
    step(1);
    chk(err_o == 0, "R2 err clears", err_o, 0);
    post(8'h21); chk(status_o == 8'h21, "R2 post ORs", status_o, 8'h21);
    post(8'h40); chk(status_o == 8'h61, "R2 post ORs again", status_o, 8'h61);
    clr(8'h81); chk(status_o == 8'h61, "R2 reserved clear ignored", status_o, 8'h61);
    chk(err_o == 1, "R2 err on clear", err_o, 1);

    // R5 later request does not postpone
    do_reset(); delay_cyc = 8; post(8'h01); step(3);
    delay_cyc = 10; post(8'h02); wait_irq(20, lat);
    chk(lat == 4, "R5 not postponed", lat, 4);
    // R5 earlier request pulls in
    do_reset(); delay_cyc = 8; post(8'h01); step(1);
    delay_cyc = 2; post(8'h02); wait_irq(20, lat);
    chk(lat == 2, "R5 pulled earlier", lat, 2);

    // R6 clear
    do_reset(); post(8'h03);
    chk(irq_o == 1, "R6 setup irq", irq_o, 1);
    clr(8'h01);
    chk(irq_o == 1 && status_o == 8'h02, "R6 partial clear keeps irq", {irq_o, status_o}, 9'h102);
    clr(8'h02);
    chk(irq_o == 0 && status_o == 0, "R6 full clear withdraws", {irq_o, status_o}, 0);
    do_reset(); delay_cyc = 5; post(8'h01); step(2); clr(8'h01); wait_irq(10, lat);
    chk(lat == -1, "R6 clear cancels schedule", lat, -1);
    do_reset(); post_vld = 1; post_bits = 8'h01; clr_vld = 1; clr_bits = 8'h01; step(1);
    post_vld = 0; clr_vld = 0;
    chk(status_o == 0 && !irq_o, "R6 post then clear same cycle", {irq_o, status_o}, 0);

    // R7 mask writes
    do_reset(); delay_cyc = 10; post(8'h20);
    chk(!irq_o, "R7 masked post", irq_o, 0);
    wmask(8'h27);
    chk(irq_o == 1 && mask_o == 8'h27, "R7 mask change immediate", {irq_o, mask_o}, 9'h127);
    ack(); wmask(8'h27); wait_irq(12, lat);
    chk(lat == -1, "R7 equal mask no effect", lat, -1);

    // R8 enable
    do_reset(); glb_en = 0; post(8'h01); wait_irq(5, lat);
    chk(lat == -1, "R8 disabled no irq", lat, -1);
    glb_en = 1; step(1);
    chk(irq_o == 1, "R8 enable rise immediate", irq_o, 1);
    do_reset(); delay_cyc = 5; post(8'h01); step(1); glb_en = 0; wait_irq(10, lat);
    chk(lat == -1, "R8 disable cancels schedule", lat, -1);

    // R9 pending
    do_reset(); post(8'h01); post(8'h02);
    chk(irq_o == 1, "R9 stays high", irq_o, 1);
    ack();
    chk(irq_o == 0, "R10 ack drops", irq_o, 0);
    post(8'h04);
    chk(irq_o == 1, "R9 fires again after ack", irq_o, 1);

    // R10 ack cancels schedule
    do_reset(); delay_cyc = 6; post(8'h01); step(2); ack(); wait_irq(12, lat);
    chk(lat == -1, "R10 ack cancels schedule", lat, -1);
    do_reset(); delay_cyc = 0; cpu_ack = 1; post(8'h01); cpu_ack = 0;
    chk(irq_o == 0, "R10 ack beats firing", irq_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule